// File: doc/BRIEF.md
# Burst Address Sequence Generator

This block produces the word address that a synchronous burst memory uses in each cycle. A burst starts when either of two start strobes is high at a rising clock edge. One strobe comes from the processor side and the other from the memory controller side. On that edge the block captures the external address. After that, every cycle with the advance strobe high moves the low address field one beat forward. The upper address field does not change until the next start.

The low field is `CNT_W` bits wide, two by default, which gives a four-beat burst. It can step in linear order, where the start value is incremented and wraps. It can also step in interleaved order, where the start value is XORed with the beat number. A static order input selects between the two. Bursting is optional: a controller can pulse a start strobe in every cycle and get a fresh address each cycle. The outputs are the registered address and the registered beat index, so a consumer can align its own data path to them.

Top module: `burst_addr_gen`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it is released, `cur_addr` is all zeros and `beat` is 0.
- R2: When `start_cpu` or `start_ctl` (or both) is 1 at a rising edge, `cur_addr` equals the sampled `ext_addr` and `beat` equals 0 after that edge.
- R3: The bits of `cur_addr` above the low `CNT_W` bits change only on an edge that loads a new address. No beat step carries into them.
- R4: When neither start strobe nor `advance` is 1 at an edge, `cur_addr` and `beat` keep their values.
- R5: When `advance` is 1 and no start strobe is 1, `beat` increments modulo 2^CNT_W. After the last beat it wraps to 0, and the low field returns to the loaded start value.
- R6: With `order_lin` = 1 (linear), the low field equals (start + beat) modulo 2^CNT_W.
- R7: With `order_lin` = 0 (interleaved), the low field equals start XOR beat. `order_lin` may change only in a cycle that loads a new address.
- R8: When a start strobe and `advance` are both 1 at the same edge, the load takes effect and the advance is ignored: `beat` is 0 and `cur_addr` equals `ext_addr`.
- R9: Loads on consecutive edges each take effect at once, with no idle cycle between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_addr | input | ADDR_W | External word address, captured when a burst starts |
| start_cpu | input | 1 | Processor-side burst start strobe |
| start_ctl | input | 1 | Controller-side burst start strobe |
| advance | input | 1 | Step to the next beat of the current burst |
| order_lin | input | 1 | 1 = linear order, 0 = interleaved order |
| cur_addr | output | ADDR_W | Registered address for the current beat |
| beat | output | CNT_W | Registered beat index within the burst |

## Verification
A start and an advance can fall in the same clock cycle, and a start can also coincide with a change of counting order. Directed cases drive a start strobe together with `advance` in the middle of a burst and at its last beat. Random stimulus raises each strobe independently, so the two combinations also appear many times. In each such cycle, the result is judged correct only if the next outputs show exactly the new external address with beat 0. An address one beat past the previous burst, or a beat that did not reset, fails the check.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
   typedef enum logic {
      ORD_INTERLEAVE = 1'b0,
      ORD_LINEAR     = 1'b1
   } burst_order_e;
endpackage

// File: rtl/burst_beat_ctr.sv
module burst_beat_ctr #(
   parameter int CNT_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic             adv,
   output logic [CNT_W-1:0] beat_q,
   output logic [CNT_W-1:0] beat_nxt
);
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   always_comb begin
      if (load)
         beat_nxt = '0;
      else if (adv)
         beat_nxt = beat_q + ONE;
      else
         beat_nxt = beat_q;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         beat_q <= '0;
      else
         beat_q <= beat_nxt;
   end
endmodule

// File: rtl/burst_base_reg.sv
module burst_base_reg #(
   parameter int ADDR_W = 20,
   parameter int CNT_W  = 2,
   localparam int HI_W  = ADDR_W - CNT_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [ADDR_W-1:0] ext_addr,
   output logic [HI_W-1:0]   upper_nxt,
   output logic [CNT_W-1:0]  start_nxt
);
   logic [HI_W-1:0]  upper_q;
   logic [CNT_W-1:0] start_q;

   assign upper_nxt = load ? ext_addr[ADDR_W-1:CNT_W] : upper_q;
   assign start_nxt = load ? ext_addr[CNT_W-1:0]      : start_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         upper_q <= '0;
         start_q <= '0;
      end else begin
         upper_q <= upper_nxt;
         start_q <= start_nxt;
      end
   end
endmodule

// File: rtl/burst_order_map.sv
module burst_order_map
   import burst_seq_pkg::*;
#(
   parameter int CNT_W = 2
) (
   input  logic [CNT_W-1:0] start_low,
   input  logic [CNT_W-1:0] beat_idx,
   input  burst_order_e     order,
   output logic [CNT_W-1:0] low_out
);
   logic [CNT_W-1:0] lin_low;
   logic [CNT_W-1:0] ilv_low;

   assign lin_low = start_low + beat_idx;

   for (genvar i = 0; i < CNT_W; i++) begin : g_ilv
      assign ilv_low[i] = start_low[i] ^ beat_idx[i];
   end

   assign low_out = (order == ORD_LINEAR) ? lin_low : ilv_low;
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
   import burst_seq_pkg::*;
#(
   parameter int ADDR_W = 20,
   parameter int CNT_W  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] ext_addr,
   input  logic              start_cpu,
   input  logic              start_ctl,
   input  logic              advance,
   input  logic              order_lin,
   output logic [ADDR_W-1:0] cur_addr,
   output logic [CNT_W-1:0]  beat
);
   localparam int HI_W = ADDR_W - CNT_W;

   if (CNT_W < 1 || CNT_W > 8) begin : g_bad_cnt
      $error("burst_addr_gen: CNT_W must be 1..8");
   end
   if (ADDR_W <= CNT_W) begin : g_bad_addr
      $error("burst_addr_gen: ADDR_W must exceed CNT_W");
   end

   logic             load;
   logic [CNT_W-1:0] beat_nxt;
   logic [HI_W-1:0]  upper_nxt;
   logic [CNT_W-1:0] start_nxt;
   logic [CNT_W-1:0] low_nxt;
   logic [ADDR_W-1:0] addr_q;
   burst_order_e     order;

   assign load  = start_cpu | start_ctl;
   assign order = burst_order_e'(order_lin);

   burst_beat_ctr #(.CNT_W(CNT_W)) u_ctr (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (load),
      .adv     (advance),
      .beat_q  (beat),
      .beat_nxt(beat_nxt)
   );

   burst_base_reg #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_base (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (load),
      .ext_addr (ext_addr),
      .upper_nxt(upper_nxt),
      .start_nxt(start_nxt)
   );

   burst_order_map #(.CNT_W(CNT_W)) u_map (
      .start_low(start_nxt),
      .beat_idx (beat_nxt),
      .order    (order),
      .low_out  (low_nxt)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)
         addr_q <= '0;
      else
         addr_q <= {upper_nxt, low_nxt};
   end

   assign cur_addr = addr_q;
endmodule

// File: rtl/burst_addr_gen_chk.sv
module burst_addr_gen_chk #(
   parameter int ADDR_W = 20,
   parameter int CNT_W  = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] ext_addr,
   input logic              start_cpu,
   input logic              start_ctl,
   input logic              advance,
   input logic              order_lin,
   input logic [ADDR_W-1:0] cur_addr,
   input logic [CNT_W-1:0]  beat
);
   logic             ld;
   logic [CNT_W-1:0] lo;
   logic [CNT_W-1:0] lo_inc;
   logic [CNT_W-1:0] beat_inc;

   assign ld       = start_cpu | start_ctl;
   assign lo       = cur_addr[CNT_W-1:0];
   assign lo_inc   = lo + CNT_W'(1);
   assign beat_inc = beat + CNT_W'(1);

   // R2, R8, R9
   a_r2_load_takes_addr: assert property (@(posedge clk) disable iff (!rst_n)
      ld |=> (cur_addr == $past(ext_addr)) && (beat == '0));

   a_r3_upper_no_carry: assert property (@(posedge clk) disable iff (!rst_n)
      !ld |=> cur_addr[ADDR_W-1:CNT_W] == $past(cur_addr[ADDR_W-1:CNT_W]));

   a_r4_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!ld && !advance) |=> $stable(cur_addr) && $stable(beat));

   a_r5_beat_step: assert property (@(posedge clk) disable iff (!rst_n)
      (!ld && advance) |=> beat == $past(beat_inc));

   a_r6_linear_step: assert property (@(posedge clk) disable iff (!rst_n)
      (!ld && advance && order_lin) |=> lo == $past(lo_inc));

   a_r7_interleave_step: assert property (@(posedge clk) disable iff (!rst_n)
      (!ld && advance && !order_lin) |=> (lo ^ $past(lo)) == (beat ^ $past(beat)));
endmodule

bind burst_addr_gen burst_addr_gen_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (.*);

// File: tb/sim_burst_addr_gen.sv
`timescale 1ns/1ps
module sim_burst_addr_gen;
   localparam int AW = 20;
   localparam int CW = 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [AW-1:0] ext_addr = '0;
   logic          start_cpu = 1'b0;
   logic          start_ctl = 1'b0;
   logic          advance = 1'b0;
   logic          order_lin = 1'b0;
   logic [AW-1:0] cur_addr;
   logic [CW-1:0] beat;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   logic [AW-1:0] m_base = '0;
   logic [CW-1:0] m_beat = '0;
   logic          m_lin  = 1'b0;

   always #10 clk = ~clk;

   burst_addr_gen #(.ADDR_W(AW), .CNT_W(CW)) u0 (
      .clk(clk), .rst_n(rst_n), .ext_addr(ext_addr),
      .start_cpu(start_cpu), .start_ctl(start_ctl), .advance(advance),
      .order_lin(order_lin), .cur_addr(cur_addr), .beat(beat)
   );

   function automatic logic [AW-1:0] exp_addr(logic [AW-1:0] base, logic [CW-1:0] b, logic lin);
      logic [CW-1:0] lo;
      lo = lin ? (base[CW-1:0] + b) : (base[CW-1:0] ^ b);
      return {base[AW-1:CW], lo};
   endfunction

   task automatic check(string tag);
      logic [AW-1:0] ea;
      ea = exp_addr(m_base, m_beat, m_lin);
      n_chk++;
      if (cur_addr !== ea || beat !== m_beat) begin
         n_fail++;
         $display("FAIL %s: addr=%h beat=%0d expected addr=%h beat=%0d",
                  tag, cur_addr, beat, ea, m_beat);
      end
   endtask

   // called at a negedge; drives, crosses one posedge, checks at the next negedge
   task automatic step(logic cpu, logic ctl, logic adv, logic lin, logic [AW-1:0] a, string tag);
      start_cpu = cpu; start_ctl = ctl; advance = adv; ext_addr = a;
      if (cpu || ctl) order_lin = lin;
      @(posedge clk);
      #1;
      if (cpu || ctl) begin
         m_base = a; m_beat = '0; m_lin = lin;
      end else if (adv) begin
         m_beat = m_beat + 1'b1;
      end
      @(negedge clk);
      check(tag);
   endtask

   initial begin
      #(20 * 150000);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: run did not complete");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd4711));
      repeat (3) @(negedge clk);
      check("R1 during reset");
      rst_n = 1'b1;
      @(posedge clk); @(negedge clk);
      check("R1 after release");

      // R5/R6 linear burst from low=3 with upper all ones: wrap, no carry (R3)
      step(1, 0, 0, 1, {{(AW-CW){1'b1}}, 2'b11}, "R2 cpu load");
      for (int k = 0; k < 4; k++) step(0, 0, 1, 1, '0, "R6 linear R3 no carry");
      step(0, 0, 1, 1, '0, "R5 wrap again");
      step(0, 0, 0, 1, 20'h12345, "R4 idle hold");

      // R7 interleaved burst from low=1
      step(0, 1, 0, 0, 20'hABCD1, "R2 ctl load");
      for (int k = 0; k < 5; k++) step(0, 0, 1, 0, '0, "R7 interleave R5 wrap");

      // R8 start with advance, mid-burst and at last beat
      step(0, 0, 1, 0, '0, "R5 step");
      step(1, 0, 1, 1, 20'h0F0F2, "R8 start beats advance");
      step(0, 0, 1, 1, '0, "R6 step");
      step(0, 0, 1, 1, '0, "R6 step");
      step(0, 0, 1, 1, '0, "R6 last beat");
      step(1, 1, 1, 0, 20'h55553, "R8 both strobes plus advance");

      // R9 back-to-back loads
      for (int k = 0; k < 6; k++)
         step(k[0], ~k[0], 0, k[1], AW'(32'h1000 * k + k), "R9 back to back");

      // random mix
      for (int k = 0; k < 4000; k++) begin
         logic ldr, c, t, a, l;
         string tg;
         ldr = ($urandom % 4) == 0;
         c = ldr && ($urandom % 2);
         t = ldr && (!c || ($urandom % 2));
         a = ($urandom % 3) != 0;
         l = $urandom % 2;
         if (ldr && a) tg = "R8 random";
         else if (ldr) tg = "R2 random";
         else if (a) tg = m_lin ? "R6 random" : "R7 random";
         else tg = "R4 random";
         step(c, t, a, l, AW'($urandom), tg);
      end

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule